// File: doc/BRIEF.md
# Isochronous Transmit Timestamp Inserter

This block sits in the transmit path of a serial-bus isochronous link. It rewrites the presentation timestamps in outgoing audio/video stream packets. Packets enter as a stream of 32-bit words with a valid/ready handshake and leave one cycle later. The only words that change are the timestamp words of the stream types the block recognises.

For DV streams, on the packet that starts a DV frame, the block adds the transmit context's offset to the running cycle timer. It packs the sum into the 16-bit SYT field of the second CIP quadlet. For MPEG2 transport streams, every source-packet timestamp gets the context's user offset added. Unless the context disables it, the timestamp also gets an initial delta. That delta is captured from the first source packet the context sends after MPEG handling is switched on.

Software turns each mode on through a control register that has a set alias and a clear alias. Eight per-context offset registers supply the offsets. Both kinds of arithmetic use cycle-timer units. The 12-bit offset wraps at 3072 and carries into the 13-bit count. The count wraps at 8000.

Top module: `iso_ts_inserter`

## Requirements
- R1: An accepted input word appears on `out_data` at the next clock edge. `in_ready` is high whenever the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.
- R2: A write through the set alias sets each control bit whose write-data bit is 1. Bits written as 0 keep their value. The control register is read back on `ctl_state`.
- R3: A write through the clear alias clears each control bit whose write-data bit is 1. Bits written as 0 keep their value. When both aliases are written in the same cycle, clearing wins.
- R4: There are eight offset registers, one per transmit context, selected by `ofs_sel`. A packet uses the register of the context presented on `in_ctx` with its first word (`in_sop`).
- R5: DV substitution happens when control bit 8 is 1, `in_frame` was high with the first word, the tag (word 0 bits 15:14) is 01b, and FMT (word 2 bits 29:24) is 00h. Word 2 bits 15:0 then become {count[3:0], offset[11:0]} of cycle timer plus offset register. Bits 31:16 pass unchanged.
- R6: A DV packet without the frame-start flag, or sent while bit 8 is 0, passes through unchanged.
- R7: MPEG2 handling applies only when control bit 10 is 1, the tag is 01b and FMT is 10h. Any other packet passes through unchanged.
- R8: In an MPEG2 packet the timestamp words are words 3 + k·SP_WORDS. Only bits 24:0 of them change: count in 24:12, offset in 11:0. All other words and bits pass unchanged.
- R9: Timestamp sums wrap the offset at 3072 with a carry into the count, and wrap the count at 8000. The 7 seconds bits of the cycle timer (31:25) are not used.
- R10: On a context's first MPEG2 timestamp word after bit 10 is set, the block latches a delta of (cycle-timer count − timestamp count) mod 8000. It applies that delta to that word and to every later word of the context. The delta stays fixed until bit 10 is cleared.
- R11: When bit 31 of the context's offset register is 1, the block adds only the offset register's bits 24:0. The delta is still latched.
- R12: Clearing bit 10 discards all latched deltas. After bit 10 is set again, the next qualifying timestamp word latches a fresh delta.
- R13: After reset, `out_valid` is 0, `in_ready` is 1, the control register is 0 and all offset registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_timer | input | 32 | Running cycle timer {seconds[6:0], count[12:0], offset[11:0]} |
| en_set_we | input | 1 | Write strobe of the control set alias |
| en_clr_we | input | 1 | Write strobe of the control clear alias |
| en_wdata | input | 32 | Write data for either control alias |
| ofs_we | input | 1 | Offset register write strobe |
| ofs_sel | input | CTX_W | Offset register index (context) |
| ofs_wdata | input | 32 | Offset register write data |
| ctl_state | output | 32 | Control register contents |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_sop | input | 1 | Input word is the first word of a packet |
| in_frame | input | 1 | Packet starts a DV frame (sampled with in_sop) |
| in_ctx | input | CTX_W | Transmit context of the packet (sampled with in_sop) |
| in_data | input | 32 | Input packet word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_sop | output | 1 | Output word is the first of a packet |
| out_data | output | 32 | Output packet word |

## Verification
DV substitution is tried with cycle-timer and offset pairs that include no carry, an offset carry, a count wrap past 8000, and a combined carry-and-wrap to zero. This separates a correct modular sum from one that only truncates. MPEG2 packets carry several source packets per packet, which shows whether only the slot words change. The same context is sent twice with different cycle timers. If the delta were recomputed, the second packet's words would differ, so a latched delta can be told apart from a recomputed one. Packets with a wrong tag, a wrong FMT, a disabled mode or the delta-disable bit each differ from a qualifying packet in one condition only. Each of those conditions is therefore shown to gate the rewrite on its own.

// File: rtl/its_pkg.sv
package its_pkg;

  localparam int unsigned CNT_MOD = 8000;
  localparam int unsigned OFF_MOD = 3072;

  localparam int unsigned DV_EN_BIT    = 8;
  localparam int unsigned MPEG_EN_BIT  = 10;
  localparam int unsigned NO_DELTA_BIT = 31;

  localparam logic [1:0] TAG_CIP  = 2'b01;
  localparam logic [5:0] FMT_DV   = 6'h00;
  localparam logic [5:0] FMT_MPEG = 6'h10;

  typedef struct packed {
    logic [12:0] cnt;
    logic [11:0] off;
  } ts_t;

  function automatic logic [1:0] tag_of(logic [31:0] w);
    return w[15:14];
  endfunction

  function automatic logic [5:0] fmt_of(logic [31:0] w);
    return w[29:24];
  endfunction

  // modular add: offset wraps at OFF_MOD carrying into count, count wraps at CNT_MOD
  function automatic ts_t ts_add(ts_t a, ts_t b);
    ts_t r;
    logic [12:0] s;
    logic [13:0] c;
    logic cy;
    s  = {1'b0, a.off} + {1'b0, b.off};
    cy = (s >= 13'(OFF_MOD));
    if (cy) s = s - 13'(OFF_MOD);
    c = {1'b0, a.cnt} + {1'b0, b.cnt} + {13'd0, cy};
    if (c >= 14'(CNT_MOD)) c = c - 14'(CNT_MOD);
    r.cnt = c[12:0];
    r.off = s[11:0];
    return r;
  endfunction

  // (a - b) mod CNT_MOD
  function automatic logic [12:0] cnt_sub(logic [12:0] a, logic [12:0] b);
    logic [13:0] d;
    if (a >= b) d = {1'b0, a} - {1'b0, b};
    else        d = {1'b0, a} + 14'(CNT_MOD) - {1'b0, b};
    return d[12:0];
  endfunction

  function automatic logic [15:0] syt_of(ts_t t);
    return {t.cnt[3:0], t.off};
  endfunction

endpackage

// File: rtl/its_ctl_regs.sv
module its_ctl_regs #(
  parameter int N_CTX = 8,
  localparam int CTX_W = $clog2(N_CTX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_set_we,
  input  logic                   en_clr_we,
  input  logic [31:0]            en_wdata,
  input  logic                   ofs_we,
  input  logic [CTX_W-1:0]       ofs_sel,
  input  logic [31:0]            ofs_wdata,
  output logic [31:0]            ctl_q,
  output logic [N_CTX-1:0][31:0] ofs_q
);

  logic [31:0] ctl_nxt;

  always_comb begin
    ctl_nxt = ctl_q;
    if (en_set_we) ctl_nxt = ctl_nxt | en_wdata;
    if (en_clr_we) ctl_nxt = ctl_nxt & ~en_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_nxt;
  end

  for (genvar i = 0; i < N_CTX; i++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (!rst_n)                                 ofs_q[i] <= '0;
      else if (ofs_we && ofs_sel == CTX_W'(i))    ofs_q[i] <= ofs_wdata;
    end
  end

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we && !en_clr_we |=> (ctl_q & $past(en_wdata)) == $past(en_wdata));
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> (ctl_q & $past(en_wdata)) == 32'd0);
  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_we || en_clr_we) |=> ((ctl_q ^ $past(ctl_q)) & ~$past(en_wdata)) == 32'd0);
  a_r3_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !en_set_we && !en_clr_we |=> $stable(ctl_q));

endmodule

// File: rtl/its_pkt_pos.sv
module its_pkt_pos #(
  parameter int SP_WORDS = 48,
  localparam int SP_W = (SP_WORDS > 1) ? $clog2(SP_WORDS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       sop,
  output logic [1:0] cur_idx,  // 0..2 header words, 3 = payload
  output logic       ts_slot
);

  logic [1:0]      idx_q;
  logic [SP_W-1:0] sp_q;

  assign cur_idx = sop ? 2'd0 : idx_q;
  assign ts_slot = (cur_idx == 2'd3) && (sp_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      sp_q  <= '0;
    end else if (acc) begin
      if (cur_idx != 2'd3) begin
        idx_q <= cur_idx + 2'd1;
        sp_q  <= '0;
      end else begin
        sp_q <= (sp_q == SP_W'(SP_WORDS - 1)) ? '0 : sp_q + 1'b1;
      end
    end
  end

  a_r8_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(SP_WORDS - 1));
  a_r8_sop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sop |=> idx_q == 2'd1 && sp_q == '0);

endmodule

// File: rtl/its_delta_store.sv
module its_delta_store #(
  parameter int N_CTX = 8,
  localparam int CTX_W = $clog2(N_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cap,
  input  logic [CTX_W-1:0] ctx,
  input  logic [12:0]      cap_val,
  output logic             cur_vld,
  output logic [12:0]      cur_delta
);

  logic [N_CTX-1:0]       vld_q;
  logic [N_CTX-1:0][12:0] dl_q;

  assign cur_vld   = vld_q[ctx];
  assign cur_delta = dl_q[ctx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      dl_q  <= '0;
    end else if (!en) begin
      vld_q <= '0;
    end else if (cap && !vld_q[ctx]) begin
      vld_q[ctx] <= 1'b1;
      dl_q[ctx]  <= cap_val;
    end
  end

  for (genvar i = 0; i < N_CTX; i++) begin : g_chk
    a_r12_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !vld_q[i]);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[i] && en |=> vld_q[i] && $stable(dl_q[i]));
  end

endmodule

// File: rtl/iso_ts_inserter.sv
module iso_ts_inserter
  import its_pkg::*;
#(
  parameter int N_CTX    = 8,
  parameter int SP_WORDS = 48,
  localparam int CTX_W   = $clog2(N_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cycle_timer,
  input  logic             en_set_we,
  input  logic             en_clr_we,
  input  logic [31:0]      en_wdata,
  input  logic             ofs_we,
  input  logic [CTX_W-1:0] ofs_sel,
  input  logic [31:0]      ofs_wdata,
  output logic [31:0]      ctl_state,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sop,
  input  logic             in_frame,
  input  logic [CTX_W-1:0] in_ctx,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sop,
  output logic [31:0]      out_data
);

  logic [N_CTX-1:0][31:0] ofs_q;
  logic [1:0]             cur_idx;
  logic                   ts_slot;
  logic                   acc;
  logic [CTX_W-1:0]       ctx_q;
  logic                   tag_ok_q, frame_q, mpeg_q;
  logic                   dv_hit, mp_hit;
  logic                   dl_vld;
  logic [12:0]            dl_stored, dl_fresh, dl_used, dl_add;
  ts_t                    ct_ts, ofs_ts, in_ts, dl_ts, dv_ts, mp_ts;
  logic [31:0]            ofs_cur, word_mod;

  its_ctl_regs #(.N_CTX(N_CTX)) u_regs (
    .clk, .rst_n, .en_set_we, .en_clr_we, .en_wdata,
    .ofs_we, .ofs_sel, .ofs_wdata, .ctl_q(ctl_state), .ofs_q
  );

  its_pkt_pos #(.SP_WORDS(SP_WORDS)) u_pos (
    .clk, .rst_n, .acc, .sop(in_sop), .cur_idx, .ts_slot
  );

  its_delta_store #(.N_CTX(N_CTX)) u_delta (
    .clk, .rst_n, .en(ctl_state[MPEG_EN_BIT]), .cap(mp_hit), .ctx(ctx_q),
    .cap_val(dl_fresh), .cur_vld(dl_vld), .cur_delta(dl_stored)
  );

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  // per-packet context and qualification
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_q <= '0; tag_ok_q <= 1'b0; frame_q <= 1'b0; mpeg_q <= 1'b0;
    end else if (acc) begin
      if (in_sop) begin
        ctx_q    <= in_ctx;
        frame_q  <= in_frame;
        tag_ok_q <= (tag_of(in_data) == TAG_CIP);
        mpeg_q   <= 1'b0;
      end else if (cur_idx == 2'd2) begin
        mpeg_q <= tag_ok_q && (fmt_of(in_data) == FMT_MPEG);
      end
    end
  end

  assign ofs_cur = ofs_q[ctx_q];
  assign ofs_ts  = ofs_cur[24:0];
  assign ct_ts   = cycle_timer[24:0];
  assign in_ts   = in_data[24:0];

  assign dv_hit = acc && (cur_idx == 2'd2) && tag_ok_q && frame_q &&
                  (fmt_of(in_data) == FMT_DV) && ctl_state[DV_EN_BIT];
  assign mp_hit = acc && ts_slot && mpeg_q && ctl_state[MPEG_EN_BIT];

  assign dl_fresh = cnt_sub(ct_ts.cnt, in_ts.cnt);
  assign dl_used  = dl_vld ? dl_stored : dl_fresh;
  assign dl_add   = ofs_cur[NO_DELTA_BIT] ? 13'd0 : dl_used;
  assign dl_ts    = '{cnt: dl_add, off: 12'd0};
  assign dv_ts    = ts_add(ct_ts, ofs_ts);
  assign mp_ts    = ts_add(ts_add(in_ts, ofs_ts), dl_ts);

  always_comb begin
    word_mod = in_data;
    if (dv_hit) word_mod[15:0] = syt_of(dv_ts);
    if (mp_hit) word_mod[24:0] = mp_ts;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_sop   <= in_sop;
      out_data  <= word_mod;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid && out_sop == $past(in_sop));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !dv_hit && !mp_hit |=> out_data == $past(in_data));
  a_r5_dv_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    dv_hit |=> out_data[31:16] == $past(in_data[31:16]));
  a_r8_mp_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mp_hit |=> out_data[31:25] == $past(in_data[31:25]));
  a_r7_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !(dv_hit && mp_hit));

endmodule

// File: tb/test_iso_ts_inserter.sv
`timescale 1ns/1ps
module test_iso_ts_inserter;

  localparam int SPW  = 4;
  localparam int NW   = 3 + 3 * SPW;
  localparam int TMOD = 8000 * 3072;

  // DV table: ct count, ct offset, ofs count, ofs offset, expected SYT
  localparam int DV_TAB [6][5] = '{
    '{100,  200,  3,  100, 'h712C},
    '{10,   3000, 0,  100, 'hB01C},
    '{7999, 3071, 0,  1,   'h0000},
    '{7990, 0,    20, 5,   'hA005},
    '{4095, 1536, 1,  1536,'h1000},
    '{33,   17,   0,  0,   'h1011}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cycle_timer = '0;
  logic        en_set_we = 1'b0, en_clr_we = 1'b0;
  logic [31:0] en_wdata = '0;
  logic        ofs_we = 1'b0;
  logic [2:0]  ofs_sel = '0;
  logic [31:0] ofs_wdata = '0;
  logic [31:0] ctl_state;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_frame = 1'b0;
  logic [2:0]  in_ctx = '0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_sop;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_chk = 0, n_err = 0;
  logic [31:0] pin  [NW];
  logic [31:0] pexp [NW];
  logic [31:0] ofs_m [8];
  logic        dok_m [8];
  logic [12:0] dl_m  [8];
  bit          mpeg_on = 0;

  always #2.5 clk = ~clk;

  iso_ts_inserter #(.N_CTX(8), .SP_WORDS(SPW)) i_iso_ts_inserter (
    .clk, .rst_n, .cycle_timer, .en_set_we, .en_clr_we, .en_wdata,
    .ofs_we, .ofs_sel, .ofs_wdata, .ctl_state, .in_valid, .in_ready,
    .in_sop, .in_frame, .in_ctx, .in_data, .out_valid, .out_ready,
    .out_sop, .out_data
  );

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint ticks(logic [24:0] t);
    return longint'(t[24:12]) * 3072 + longint'(t[11:0]);
  endfunction

  function automatic logic [24:0] tk_add(logic [24:0] a, logic [24:0] b);
    longint s;
    s = (ticks(a) + ticks(b)) % TMOD;
    return {13'(s / 3072), 12'(s % 3072)};
  endfunction

  task automatic set_ctl(logic [31:0] d);
    @(negedge clk); en_set_we = 1'b1; en_wdata = d;
    @(negedge clk); en_set_we = 1'b0;
  endtask

  task automatic clr_ctl(logic [31:0] d);
    @(negedge clk); en_clr_we = 1'b1; en_wdata = d;
    @(negedge clk); en_clr_we = 1'b0;
    if (d[10]) begin
      mpeg_on = 0;
      for (int i = 0; i < 8; i++) dok_m[i] = 1'b0;
    end
  endtask

  task automatic wr_ofs(int ctx, logic [31:0] d);
    @(negedge clk); ofs_we = 1'b1; ofs_sel = 3'(ctx); ofs_wdata = d;
    @(negedge clk); ofs_we = 1'b0;
    ofs_m[ctx] = d;
  endtask

  task automatic run_pkt(int n, int ctx, bit frame, string req);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) chk(out_data, pexp[k-1], req);
      if (k < n) begin
        in_valid = 1'b1; in_data = pin[k]; in_sop = (k == 0);
        in_ctx = 3'(ctx); in_frame = frame;
      end else begin
        in_valid = 1'b0; in_sop = 1'b0;
      end
    end
  endtask

  // header words: tag in word0[15:14], FMT in word2[29:24]
  task automatic build_hdr(logic [1:0] tag, logic [5:0] fmt);
    pin[0] = {16'd60, tag, 6'd5, 4'hA, 4'h0};
    pin[1] = 32'h0102_0304;
    pin[2] = {2'b10, fmt, 8'h44, 16'hFFFF};
  endtask

  task automatic build_mpeg(logic [1:0] tag, logic [5:0] fmt, int ctx,
                            logic [24:0] t0, logic [24:0] t1, logic [24:0] t2);
    logic [24:0] ts [3];
    logic [24:0] r;
    logic [12:0] d;
    bit q;
    ts[0] = t0; ts[1] = t1; ts[2] = t2;
    q = mpeg_on && tag == 2'b01 && fmt == 6'h10;
    build_hdr(tag, fmt);
    for (int k = 3; k < NW; k++) pin[k] = 32'hC0DE_0000 + 32'(k);
    for (int k = 0; k < 3; k++) pin[3 + k*SPW] = {7'h5A, ts[k]};
    for (int k = 0; k < NW; k++) pexp[k] = pin[k];
    if (q) begin
      for (int k = 0; k < 3; k++) begin
        if (!dok_m[ctx]) begin
          dl_m[ctx]  = 13'((int'(cycle_timer[24:12]) - int'(ts[k][24:12]) + 8000) % 8000);
          dok_m[ctx] = 1'b1;
        end
        d = ofs_m[ctx][31] ? 13'd0 : dl_m[ctx];
        r = tk_add(tk_add(ts[k], ofs_m[ctx][24:0]), {d, 12'd0});
        pexp[3 + k*SPW] = {7'h5A, r};
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin ofs_m[i] = '0; dok_m[i] = 1'b0; dl_m[i] = '0; end
    repeat (3) @(negedge clk);
    // R13 reset state
    chk({31'd0, out_valid}, 32'd0, "R13 out_valid");
    chk({31'd0, in_ready}, 32'd1, "R13 in_ready");
    chk(ctl_state, 32'd0, "R13 ctl");
    rst_n = 1'b1;

    // R2 / R3 set and clear aliases
    set_ctl(32'h0000_0500); chk(ctl_state, 32'h0000_0500, "R2 set");
    set_ctl(32'h0);         chk(ctl_state, 32'h0000_0500, "R2 zero write");
    clr_ctl(32'h0000_0100); chk(ctl_state, 32'h0000_0400, "R3 clear");
    clr_ctl(32'h0);         chk(ctl_state, 32'h0000_0400, "R3 zero write");
    @(negedge clk); en_set_we = 1'b1; en_clr_we = 1'b1; en_wdata = 32'h0000_0100;
    @(negedge clk); en_set_we = 1'b0; en_clr_we = 1'b0;
    chk(ctl_state, 32'h0000_0400, "R3 clear wins");
    clr_ctl(32'h0000_0400); chk(ctl_state, 32'h0, "R3 all cleared");

    // R13 offset registers reset to 0: DV with zero offset gives cycle timer SYT
    set_ctl(32'h0000_0100);
    cycle_timer = {7'd1, 13'd18, 12'd5};
    build_hdr(2'b01, 6'h00);
    for (int k = 0; k < 3; k++) pexp[k] = pin[k];
    pexp[2][15:0] = {4'd2, 12'd5};
    run_pkt(3, 6, 1'b1, "R13 offset zero");

    // R5 R4 R9 DV table
    for (int i = 0; i < 6; i++) begin
      wr_ofs(i, {7'd0, 13'(DV_TAB[i][2]), 12'(DV_TAB[i][3])});
      cycle_timer = {7'd3, 13'(DV_TAB[i][0]), 12'(DV_TAB[i][1])};
      build_hdr(2'b01, 6'h00);
      for (int k = 0; k < 3; k++) pexp[k] = pin[k];
      pexp[2][15:0] = 16'(DV_TAB[i][4]);
      run_pkt(3, i, 1'b1, "R5 R4 R9 DV table");
    end

    // R6 no frame start, then DV disabled
    build_hdr(2'b01, 6'h00);
    for (int k = 0; k < 3; k++) pexp[k] = pin[k];
    run_pkt(3, 0, 1'b0, "R6 no frame");
    clr_ctl(32'h0000_0100);
    run_pkt(3, 0, 1'b1, "R6 DV off");

    // R10 R8 R9 MPEG with delta
    set_ctl(32'h0000_0400); mpeg_on = 1;
    wr_ofs(2, {7'd0, 13'd5, 12'd100});
    cycle_timer = {7'd2, 13'd1000, 12'd50};
    build_mpeg(2'b01, 6'h10, 2, {13'd990, 12'd3000}, {13'd991, 12'd10}, {13'd992, 12'd2000});
    run_pkt(NW, 2, 1'b0, "R10 R8 first delta");
    cycle_timer = {7'd2, 13'd4000, 12'd7};
    build_mpeg(2'b01, 6'h10, 2, {13'd7995, 12'd3071}, {13'd0, 12'd0}, {13'd10, 12'd5});
    run_pkt(NW, 2, 1'b0, "R10 R9 held delta");

    // R11 delta disabled per context
    wr_ofs(3, {1'b1, 6'd0, 13'd7999, 12'd3000});
    cycle_timer = {7'd0, 13'd500, 12'd0};
    build_mpeg(2'b01, 6'h10, 3, {13'd200, 12'd100}, {13'd7999, 12'd72}, {13'd1, 12'd1});
    run_pkt(NW, 3, 1'b0, "R11 no delta");

    // R7 non-qualifying packets
    build_mpeg(2'b00, 6'h10, 2, {13'd1, 12'd1}, {13'd2, 12'd2}, {13'd3, 12'd3});
    run_pkt(NW, 2, 1'b0, "R7 bad tag");
    build_mpeg(2'b01, 6'h11, 2, {13'd1, 12'd1}, {13'd2, 12'd2}, {13'd3, 12'd3});
    run_pkt(NW, 2, 1'b0, "R7 bad fmt");

    // R12 disable then re-enable recaptures
    clr_ctl(32'h0000_0400);
    build_mpeg(2'b01, 6'h10, 2, {13'd1, 12'd1}, {13'd2, 12'd2}, {13'd3, 12'd3});
    run_pkt(NW, 2, 1'b0, "R7 R12 mpeg off");
    set_ctl(32'h0000_0400); mpeg_on = 1;
    cycle_timer = {7'd0, 13'd20, 12'd0};
    build_mpeg(2'b01, 6'h10, 2, {13'd7990, 12'd0}, {13'd7991, 12'd0}, {13'd7992, 12'd0});
    run_pkt(NW, 2, 1'b0, "R12 recapture");

    // R1 backpressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_sop = 1'b1; in_data = 32'h1111_0000;
    @(negedge clk);
    chk({31'd0, out_valid}, 32'd1, "R1 valid");
    chk(out_data, 32'h1111_0000, "R1 first word");
    chk({31'd0, in_ready}, 32'd0, "R1 ready low");
    in_sop = 1'b0; in_data = 32'h2222_0001;
    @(negedge clk);
    chk(out_data, 32'h1111_0000, "R1 hold");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data, 32'h2222_0001, "R1 second word");
    @(negedge clk);
    chk({31'd0, out_valid}, 32'd0, "R1 drained");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule